// File: doc/BRIEF.md
# I2C Master Register and FIFO Front End

This block is the memory-mapped face of an I2C master. Software programs it through a simple register port with one-cycle write and read strobes. It holds the controller configuration (soft reset, enable, retry count), the bus speed selection, FIFO control, a command register, interrupt enable and status, and the push/pop windows into a 64-entry transmit queue and a 64-entry receive queue. The bit-level bus signalling lives in a separate byte engine. This block reaches that engine through a small handshake. It gives a start pulse with the command fields, presents the transmit head, accepts receive pushes, and takes a done strobe with a 3-bit result code.

A transaction runs as follows. Software writes the address byte and any payload bytes into the transmit window. It marks the final payload byte with bit 31. It then writes the command register with the start bit set. The start/busy bit stays high until the engine reports completion. At that point the result code appears in the command register and a completion flag is raised in the interrupt status. If that flag's enable is set, the interrupt output follows. For reads, the received bytes are then popped one by one from the receive window.

Top module: `i2cm_front`

## Requirements
- R1: After reset every register reads zero and irq is low. Configuration bit 30 (enable), bits 19:16 (retry count) and timing bit 31 (fast mode) read back as written and drive eng_fast_mode and eng_retry.
- R2: A write to offset 0x40 queues {bit 31 as last flag, bits 7:0 as data}. The engine sees the entries in write order on eng_tx_data/eng_tx_last while eng_tx_valid is high, and each eng_tx_pop removes one.
- R3: A read of offset 0x44 pops one receive entry and returns code in bits 31:30, the PEC error flag in bit 29 and data in bits 7:0. A read of an empty queue returns zero and leaves the occupancy at zero.
- R4: Offset 0x0C returns the receive occupancy in bits 22:16 and the threshold in bits 13:8. Writing 1 to bit 31 empties the receive queue and writing 1 to bit 30 empties the transmit queue.
- R5: A write to offset 0x30 with bit 31 set is accepted only while enabled, out of soft reset and not busy. Acceptance sets busy (bit 31) and gives a one-cycle eng_start with protocol (bits 12:9), PEC enable (bit 8) and read count (bits 7:0), which also read back. An ignored write changes nothing.
- R6: A start write while busy is already 1 produces no eng_start and leaves the command fields unchanged.
- R7: eng_done while busy clears busy and stores eng_status in command bits 27:25 (0 ok, 1 lost arbitration, 2 address NACK, 3 data NACK, 4 timeout). eng_done while idle is ignored.
- R8: Interrupt status bit 28 (offset 0x3C) is set when busy falls on completion. Writing 1 clears a status bit. irq is high only while a status bit and its enable at the same position (offset 0x38) are both 1.
- R9: Status bit 31 is set while the receive queue holds 64 entries. Status bit 30 is set while the queue is non-empty and its occupancy is at or above the threshold.
- R10: While configuration bit 31 is 1, both queues are emptied, busy, result code and command fields are cleared and the interrupt status is cleared. Starts are refused in that time.
- R11: Each queue holds at most 64 entries, and pushes into a full queue are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data valid the next cycle |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt request |
| eng_start | output | 1 | One-cycle transaction launch |
| eng_proto | output | 4 | Protocol code of the accepted command |
| eng_pec | output | 1 | PEC enable of the accepted command |
| eng_rd_cnt | output | 8 | Byte count to read |
| eng_fast_mode | output | 1 | Fast bus speed selected |
| eng_retry | output | 4 | Retry count |
| eng_tx_valid | output | 1 | Transmit queue not empty |
| eng_tx_data | output | 8 | Transmit head data |
| eng_tx_last | output | 1 | Transmit head is the final byte |
| eng_tx_pop | input | 1 | Engine consumes transmit head |
| eng_rx_push | input | 1 | Engine delivers a received byte |
| eng_rx_data | input | 8 | Received byte |
| eng_rx_stat | input | 2 | Per-byte code |
| eng_rx_pec_err | input | 1 | PEC check failed |
| eng_done | input | 1 | Transaction finished |
| eng_status | input | 3 | Result code with eng_done |

## Verification
The hardest states to reach are the full receive queue with its status flag, and soft reset arriving while a transaction is in flight with both queues loaded and status bits set. The stimulus drives the engine side directly. It pushes 66 bytes to overflow the receive queue and writes 66 bytes to overflow the transmit queue. Then, with a command busy and the threshold flag raised, it pulses the soft reset bit and confirms recovery with a fresh start. A behavioural model built on queues runs alongside and checks irq, the transmit head, start pulses and every read on each clock.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    localparam logic [7:0] A_CFG  = 8'h00;
    localparam logic [7:0] A_TIM  = 8'h04;
    localparam logic [7:0] A_FIFO = 8'h0C;
    localparam logic [7:0] A_CMD  = 8'h30;
    localparam logic [7:0] A_IE   = 8'h38;
    localparam logic [7:0] A_IS   = 8'h3C;
    localparam logic [7:0] A_TX   = 8'h40;
    localparam logic [7:0] A_RX   = 8'h44;

    typedef enum logic [2:0] {
        XS_OK     = 3'd0,
        XS_ARB    = 3'd1,
        XS_NACK_A = 3'd2,
        XS_NACK_D = 3'd3,
        XS_TMO    = 3'd4
    } xfer_status_e;

    typedef struct packed {
        logic       last;
        logic [7:0] data;
    } tx_ent_t;

    typedef struct packed {
        logic [1:0] code;
        logic       pec_bad;
        logic [7:0] data;
    } rx_ent_t;

    typedef struct packed {
        logic [3:0] proto;
        logic       pec;
        logic [7:0] rd_cnt;
    } cmd_fields_t;

    // interrupt vector: full -> bit 31, thr -> bit 30, done -> bit 28
    typedef struct packed {
        logic full;
        logic thr;
        logic done;
    } irq_vec_t;

    function automatic irq_vec_t irq_pick(logic [31:0] w);
        irq_vec_t v;
        v.full = w[31];
        v.thr  = w[30];
        v.done = w[28];
        return v;
    endfunction

    function automatic logic [31:0] irq_place(irq_vec_t v);
        return {v.full, v.thr, 1'b0, v.done, 28'b0};
    endfunction

    function automatic logic [31:0] rx_word(rx_ent_t e, logic valid);
        return valid ? {e.code, e.pec_bad, 21'b0, e.data} : 32'b0;
    endfunction

    function automatic logic [31:0] cmd_word(logic busy, logic [2:0] st, cmd_fields_t f);
        return {busy, 3'b0, st, 12'b0, f.proto, f.pec, f.rd_cnt};
    endfunction

endpackage

// File: rtl/i2cm_fifo.sv
module i2cm_fifo #(
    parameter int W     = 9,
    parameter int DEPTH = 64,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = PW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic          empty,
    output logic          full,
    output logic [CW-1:0] count
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic          do_push, do_pop;

    function automatic logic [PW-1:0] step(logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push && !rst) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= step(wp);
            if (do_pop)  rp <= step(rp);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/i2cm_cmd.sv
module i2cm_cmd
    import i2cm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        soft_rst,
    input  logic        enable,
    input  logic        go_req,
    input  cmd_fields_t fields_in,
    input  logic        eng_done,
    input  logic [2:0]  eng_status,
    output logic        busy,
    output logic [2:0]  status,
    output cmd_fields_t fields,
    output logic        start_pulse,
    output logic        fall
);
    logic accept, finish;

    assign accept = go_req && enable && !soft_rst && !busy;
    assign finish = eng_done && busy;
    assign fall   = finish && !soft_rst;

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            busy        <= 1'b0;
            status      <= XS_OK;
            fields      <= '0;
            start_pulse <= 1'b0;
        end else begin
            start_pulse <= accept;
            if (accept) begin
                busy   <= 1'b1;
                status <= XS_OK;
                fields <= fields_in;
            end else if (finish) begin
                busy   <= 1'b0;
                status <= eng_status;
            end
        end
    end
endmodule

// File: rtl/i2cm_irq.sv
module i2cm_irq
    import i2cm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     soft_rst,
    input  irq_vec_t set_v,
    input  irq_vec_t w1c_v,
    input  irq_vec_t en_v,
    output irq_vec_t stat_v,
    output logic     irq
);
    always_ff @(posedge clk) begin
        if (rst || soft_rst) stat_v <= '0;
        else                 stat_v <= (stat_v & ~w1c_v) | set_v;
    end

    assign irq = |(stat_v & en_v);
endmodule

// File: rtl/i2cm_front.sv
module i2cm_front
    import i2cm_pkg::*;
#(
    parameter int FIFO_DEPTH = 64,
    localparam int CNT_W     = $clog2(FIFO_DEPTH) + 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq,
    output logic        eng_start,
    output logic [3:0]  eng_proto,
    output logic        eng_pec,
    output logic [7:0]  eng_rd_cnt,
    output logic        eng_fast_mode,
    output logic [3:0]  eng_retry,
    output logic        eng_tx_valid,
    output logic [7:0]  eng_tx_data,
    output logic        eng_tx_last,
    input  logic        eng_tx_pop,
    input  logic        eng_rx_push,
    input  logic [7:0]  eng_rx_data,
    input  logic [1:0]  eng_rx_stat,
    input  logic        eng_rx_pec_err,
    input  logic        eng_done,
    input  logic [2:0]  eng_status
);
    logic        cfg_rst_q, cfg_en_q, fast_q;
    logic [3:0]  retry_q;
    logic [5:0]  thld_q;
    irq_vec_t    ie_q, irq_status, irq_set, irq_w1c;

    logic wr_cfg, wr_tim, wr_fifo, wr_cmd, wr_ie, wr_is, wr_tx, rd_rx;
    assign wr_cfg  = reg_wr && (reg_addr == A_CFG);
    assign wr_tim  = reg_wr && (reg_addr == A_TIM);
    assign wr_fifo = reg_wr && (reg_addr == A_FIFO);
    assign wr_cmd  = reg_wr && (reg_addr == A_CMD);
    assign wr_ie   = reg_wr && (reg_addr == A_IE);
    assign wr_is   = reg_wr && (reg_addr == A_IS);
    assign wr_tx   = reg_wr && (reg_addr == A_TX);
    assign rd_rx   = reg_rd && (reg_addr == A_RX);

    logic wdata_unused;
    assign wdata_unused = ^{reg_wdata[29], reg_wdata[27:20], reg_wdata[15:14]};

    // transmit queue
    tx_ent_t          tx_in, tx_head;
    logic             tx_empty, tx_full;
    logic [CNT_W-1:0] tx_cnt;
    assign tx_in.last = reg_wdata[31];
    assign tx_in.data = reg_wdata[7:0];

    i2cm_fifo #(.W($bits(tx_ent_t)), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst(rst),
        .flush(cfg_rst_q || (wr_fifo && reg_wdata[30])),
        .push(wr_tx), .din(tx_in), .pop(eng_tx_pop),
        .dout(tx_head), .empty(tx_empty), .full(tx_full), .count(tx_cnt)
    );

    assign eng_tx_valid = !tx_empty;
    assign eng_tx_data  = tx_head.data;
    assign eng_tx_last  = tx_head.last;

    // receive queue
    rx_ent_t          rx_in, rx_head;
    logic             rx_empty, rx_full;
    logic [CNT_W-1:0] rx_cnt;
    assign rx_in.code    = eng_rx_stat;
    assign rx_in.pec_bad = eng_rx_pec_err;
    assign rx_in.data    = eng_rx_data;

    i2cm_fifo #(.W($bits(rx_ent_t)), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst(rst),
        .flush(cfg_rst_q || (wr_fifo && reg_wdata[31])),
        .push(eng_rx_push), .din(rx_in), .pop(rd_rx),
        .dout(rx_head), .empty(rx_empty), .full(rx_full), .count(rx_cnt)
    );

    // command sequencing
    cmd_fields_t cmd_in, cmd_q;
    logic        cmd_busy, cmd_fall;
    logic [2:0]  cmd_status;
    assign cmd_in.proto  = reg_wdata[12:9];
    assign cmd_in.pec    = reg_wdata[8];
    assign cmd_in.rd_cnt = reg_wdata[7:0];

    i2cm_cmd u_cmd (
        .clk(clk), .rst(rst), .soft_rst(cfg_rst_q), .enable(cfg_en_q),
        .go_req(wr_cmd && reg_wdata[31]), .fields_in(cmd_in),
        .eng_done(eng_done), .eng_status(eng_status),
        .busy(cmd_busy), .status(cmd_status), .fields(cmd_q),
        .start_pulse(eng_start), .fall(cmd_fall)
    );

    assign eng_proto  = cmd_q.proto;
    assign eng_pec    = cmd_q.pec;
    assign eng_rd_cnt = cmd_q.rd_cnt;

    // interrupts
    assign irq_set.full = rx_full;
    assign irq_set.thr  = !rx_empty && (rx_cnt >= CNT_W'(thld_q));
    assign irq_set.done = cmd_fall;
    assign irq_w1c      = wr_is ? irq_pick(reg_wdata) : '0;

    i2cm_irq u_irq (
        .clk(clk), .rst(rst), .soft_rst(cfg_rst_q),
        .set_v(irq_set), .w1c_v(irq_w1c), .en_v(ie_q),
        .stat_v(irq_status), .irq(irq)
    );

    // control registers
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_rst_q <= 1'b0;
            cfg_en_q  <= 1'b0;
            retry_q   <= '0;
            fast_q    <= 1'b0;
            thld_q    <= '0;
            ie_q      <= '0;
        end else begin
            if (wr_cfg) begin
                cfg_rst_q <= reg_wdata[31];
                cfg_en_q  <= reg_wdata[30];
                retry_q   <= reg_wdata[19:16];
            end
            if (wr_tim)  fast_q <= reg_wdata[31];
            if (wr_fifo) thld_q <= reg_wdata[13:8];
            if (wr_ie)   ie_q   <= irq_pick(reg_wdata);
        end
    end

    assign eng_fast_mode = fast_q;
    assign eng_retry     = retry_q;

    // registered read path
    always_ff @(posedge clk) begin
        if (rst) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            case (reg_addr)
                A_CFG:   reg_rdata <= {cfg_rst_q, cfg_en_q, 10'b0, retry_q, 16'b0};
                A_TIM:   reg_rdata <= {fast_q, 31'b0};
                A_FIFO:  reg_rdata <= {9'b0, 7'(rx_cnt), 2'b0, thld_q, 8'b0};
                A_CMD:   reg_rdata <= cmd_word(cmd_busy, cmd_status, cmd_q);
                A_IE:    reg_rdata <= irq_place(ie_q);
                A_IS:    reg_rdata <= irq_place(irq_status);
                A_RX:    reg_rdata <= rx_word(rx_head, !rx_empty);
                default: reg_rdata <= '0;
            endcase
        end
    end
endmodule

// File: rtl/i2cm_front_chk.sv
module i2cm_front_chk #(
    parameter int DEPTH = 64,
    parameter int CW    = 7
) (
    input logic          clk,
    input logic          rst,
    input logic          busy,
    input logic          eng_start,
    input logic          eng_done,
    input logic          soft_rst,
    input logic [CW-1:0] tx_cnt,
    input logic [CW-1:0] rx_cnt,
    input logic [2:0]    is_vec,
    input logic [2:0]    ie_vec,
    input logic          irq
);
    // R5
    start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        eng_start |=> !eng_start);

    // R5
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        eng_start |-> busy);

    // R11
    fifo_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_cnt <= CW'(DEPTH)) && (rx_cnt <= CW'(DEPTH)));

    // R10
    soft_clear_chk: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (tx_cnt == '0 && rx_cnt == '0 && !busy && is_vec == 3'b0));

    // R8
    fall_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && eng_done && !soft_rst) |=> is_vec[0]);

    // R8
    irq_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (ie_vec != 3'b0));
endmodule

bind i2cm_front i2cm_front_chk #(.DEPTH(FIFO_DEPTH), .CW(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .busy(cmd_busy), .eng_start(eng_start),
    .eng_done(eng_done), .soft_rst(cfg_rst_q), .tx_cnt(tx_cnt),
    .rx_cnt(rx_cnt), .is_vec(irq_status), .ie_vec(ie_q), .irq(irq)
);

// File: tb/tb_i2cm_front.sv
`timescale 1ns/1ps
module tb_i2cm_front;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 0, reg_rd = 0;
    logic [7:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic        irq, eng_start, eng_pec, eng_fast_mode;
    logic [3:0]  eng_proto, eng_retry;
    logic [7:0]  eng_rd_cnt, eng_tx_data;
    logic        eng_tx_valid, eng_tx_last;
    logic        eng_tx_pop = 0, eng_rx_push = 0, eng_rx_pec_err = 0, eng_done = 0;
    logic [7:0]  eng_rx_data = 0;
    logic [1:0]  eng_rx_stat = 0;
    logic [2:0]  eng_status = 0;

    always #2.5 clk = ~clk;

    i2cm_front dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .eng_start(eng_start),
        .eng_proto(eng_proto), .eng_pec(eng_pec), .eng_rd_cnt(eng_rd_cnt),
        .eng_fast_mode(eng_fast_mode), .eng_retry(eng_retry), .eng_tx_valid(eng_tx_valid),
        .eng_tx_data(eng_tx_data), .eng_tx_last(eng_tx_last), .eng_tx_pop(eng_tx_pop),
        .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data), .eng_rx_stat(eng_rx_stat),
        .eng_rx_pec_err(eng_rx_pec_err), .eng_done(eng_done), .eng_status(eng_status)
    );

    int n_chk = 0, n_bad = 0, cyc = 0;
    string cur_tag = "R1";

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [8:0]  txq[$];
    logic [10:0] rxq[$];
    logic        m_rst, m_en, m_fast, m_busy, m_pec, m_start, m_rd_pend;
    logic [3:0]  m_retry, m_proto;
    logic [5:0]  m_thld;
    logic [7:0]  m_rdcnt;
    logic [2:0]  m_stat, m_ie, m_is;
    logic [31:0] m_rdata;
    string       m_tag;

    function automatic logic [31:0] place3(logic [2:0] v);
        return {v[2], v[1], 1'b0, v[0], 28'b0};
    endfunction

    function automatic logic [31:0] m_read(logic [7:0] a);
        logic [10:0] e;
        case (a)
            8'h00: return {m_rst, m_en, 10'b0, m_retry, 16'b0};
            8'h04: return {m_fast, 31'b0};
            8'h0C: return {9'b0, 7'(rxq.size()), 2'b0, m_thld, 8'b0};
            8'h30: return {m_busy, 3'b0, m_stat, 12'b0, m_proto, m_pec, m_rdcnt};
            8'h38: return place3(m_ie);
            8'h3C: return place3(m_is);
            8'h44: begin
                if (rxq.size() == 0) return 32'b0;
                e = rxq[0];
                return {e[10:9], e[8], 21'b0, e[7:0]};
            end
            default: return 32'b0;
        endcase
    endfunction

    always @(posedge clk) begin
        int rxn, txn;
        logic pre_rst, pre_en, pre_busy;
        logic [2:0] setv, w1c;
        if (rst) begin
            txq.delete(); rxq.delete();
            {m_rst, m_en, m_fast, m_busy, m_pec, m_start, m_rd_pend} = '0;
            m_retry = 0; m_proto = 0; m_thld = 0; m_rdcnt = 0;
            m_stat = 0; m_ie = 0; m_is = 0; m_rdata = 0;
        end else begin
            rxn = rxq.size(); txn = txq.size();
            pre_rst = m_rst; pre_en = m_en; pre_busy = m_busy;
            m_rd_pend = reg_rd;
            if (reg_rd) begin m_rdata = m_read(reg_addr); m_tag = cur_tag; end
            m_start = 0;
            if (eng_tx_pop && txn > 0) void'(txq.pop_front());
            if (reg_rd && reg_addr == 8'h44 && rxn > 0) void'(rxq.pop_front());
            if (eng_rx_push && rxn < 64) rxq.push_back({eng_rx_stat, eng_rx_pec_err, eng_rx_data});
            if (reg_wr && reg_addr == 8'h40 && txn < 64) txq.push_back({reg_wdata[31], reg_wdata[7:0]});
            setv = {rxn == 64, (rxn != 0) && (rxn >= int'(m_thld)), 1'b0};
            if (pre_rst) begin
                txq.delete(); rxq.delete();
                m_busy = 0; m_stat = 0; m_proto = 0; m_pec = 0; m_rdcnt = 0; m_is = 0;
            end else begin
                if (reg_wr && reg_addr == 8'h0C) begin
                    if (reg_wdata[31]) rxq.delete();
                    if (reg_wdata[30]) txq.delete();
                end
                if (eng_done && pre_busy) begin
                    m_busy = 0; m_stat = eng_status; setv[0] = 1'b1;
                end else if (reg_wr && reg_addr == 8'h30 && reg_wdata[31] && pre_en && !pre_busy) begin
                    m_busy = 1; m_stat = 0; m_start = 1;
                    m_proto = reg_wdata[12:9]; m_pec = reg_wdata[8]; m_rdcnt = reg_wdata[7:0];
                end
                w1c = (reg_wr && reg_addr == 8'h3C) ? {reg_wdata[31], reg_wdata[30], reg_wdata[28]} : 3'b0;
                m_is = (m_is & ~w1c) | setv;
            end
            if (reg_wr && reg_addr == 8'h00) begin
                m_rst = reg_wdata[31]; m_en = reg_wdata[30]; m_retry = reg_wdata[19:16];
            end
            if (reg_wr && reg_addr == 8'h04) m_fast = reg_wdata[31];
            if (reg_wr && reg_addr == 8'h0C) m_thld = reg_wdata[13:8];
            if (reg_wr && reg_addr == 8'h38) m_ie = {reg_wdata[31], reg_wdata[30], reg_wdata[28]};
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            check("R8 irq", {31'b0, irq}, {31'b0, |(m_is & m_ie)});
            check("R2 tx valid", {31'b0, eng_tx_valid}, {31'b0, txq.size() != 0});
            if (txq.size() != 0)
                check("R2 tx head", {23'b0, eng_tx_last, eng_tx_data}, {23'b0, txq[0]});
            check("R5 start", {31'b0, eng_start}, {31'b0, m_start});
            if (m_start)
                check("R5 fields", {19'b0, eng_proto, eng_pec, eng_rd_cnt},
                      {19'b0, m_proto, m_pec, m_rdcnt});
            if (m_rd_pend) check({m_tag, " model read"}, reg_rdata, m_rdata);
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic wr(logic [7:0] a, logic [31:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(posedge clk); @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(logic [7:0] a, string tag, logic [31:0] exp);
        cur_tag = tag;
        reg_rd = 1; reg_addr = a;
        @(posedge clk); @(negedge clk);
        reg_rd = 0;
        check(tag, reg_rdata, exp);
    endtask

    task automatic pop_tx();
        eng_tx_pop = 1;
        @(posedge clk); @(negedge clk);
        eng_tx_pop = 0;
    endtask

    task automatic push_rx(logic [7:0] d, logic [1:0] s, logic p);
        eng_rx_push = 1; eng_rx_data = d; eng_rx_stat = s; eng_rx_pec_err = p;
        @(posedge clk); @(negedge clk);
        eng_rx_push = 0;
    endtask

    task automatic done(logic [2:0] s);
        eng_done = 1; eng_status = s;
        @(posedge clk); @(negedge clk);
        eng_done = 0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 20000) begin
            n_bad++;
            $display("FAIL watchdog all-requirements act=running exp=finished");
            finish_run();
        end
    end

    initial begin
        int pops;
        logic [7:0] lastd;
        @(negedge clk); idle(3);
        rst = 0;
        idle(1);
        // R1 reset state
        rd(8'h00, "R1 cfg reset", 32'h0);
        rd(8'h30, "R1 cmd reset", 32'h0);
        rd(8'h3C, "R1 status reset", 32'h0);
        check("R1 irq reset", {31'b0, irq}, 32'h0);
        wr(8'h00, 32'h4005_0000);
        wr(8'h04, 32'h8000_0000);
        rd(8'h00, "R1 cfg readback", 32'h4005_0000);
        rd(8'h04, "R1 tim readback", 32'h8000_0000);
        check("R1 engine cfg", {27'b0, eng_fast_mode, eng_retry}, {27'b0, 1'b1, 4'd5});

        // R2 transmit ordering and last flag
        wr(8'h40, 32'h11); wr(8'h40, 32'h22); wr(8'h40, 32'h8000_0033);
        check("R2 head first", {23'b0, eng_tx_last, eng_tx_data}, 32'h011);
        pop_tx(); pop_tx();
        check("R2 head last", {23'b0, eng_tx_last, eng_tx_data}, 32'h133);
        pop_tx();
        check("R2 drained", {31'b0, eng_tx_valid}, 32'h0);

        // R5 start write transaction
        wr(8'h30, 32'h8000_0F00);
        check("R5 start pulse", {31'b0, eng_start}, 32'h1);
        check("R5 proto pec", {27'b0, eng_proto, eng_pec}, {27'b0, 4'd7, 1'b1});
        idle(1);
        check("R5 single pulse", {31'b0, eng_start}, 32'h0);
        rd(8'h30, "R5 busy readback", 32'h8000_0F00);
        // R6 start while busy
        wr(8'h30, 32'h8000_1003);
        check("R6 no second start", {31'b0, eng_start}, 32'h0);
        rd(8'h30, "R6 fields kept", 32'h8000_0F00);
        // R7 completion with address NACK
        done(3'd2);
        rd(8'h30, "R7 result code", 32'h0400_0F00);
        rd(8'h3C, "R8 done flag", 32'h1000_0000);
        check("R8 irq masked", {31'b0, irq}, 32'h0);
        wr(8'h38, 32'h1000_0000);
        check("R8 irq enabled", {31'b0, irq}, 32'h1);
        wr(8'h3C, 32'h1000_0000);
        check("R8 irq cleared", {31'b0, irq}, 32'h0);
        rd(8'h3C, "R8 w1c", 32'h0);

        // R3 read transaction and receive format
        wr(8'h30, 32'h8000_1004);
        check("R5 read cmd", {20'b0, eng_proto, eng_rd_cnt}, {20'b0, 4'd8, 8'd4});
        push_rx(8'hA1, 2'd0, 1'b0); push_rx(8'hB2, 2'd1, 1'b0);
        push_rx(8'hC3, 2'd2, 1'b1); push_rx(8'hD4, 2'd3, 1'b0);
        done(3'd0);
        check("R8 irq on done", {31'b0, irq}, 32'h1);
        rd(8'h0C, "R4 occupancy", 32'h0004_0000);
        rd(8'h44, "R3 pop 0", 32'h0000_00A1);
        rd(8'h44, "R3 pop 1", 32'h4000_00B2);
        rd(8'h44, "R3 pop 2", 32'hA000_00C3);
        rd(8'h44, "R3 pop 3", 32'hC000_00D4);
        rd(8'h44, "R3 empty read", 32'h0);
        rd(8'h0C, "R3 no underflow", 32'h0);
        wr(8'h3C, 32'hFFFF_FFFF);
        wr(8'h38, 32'h0);

        // R9 threshold and full flags, R11 receive bound
        wr(8'h0C, 32'h0000_0300);
        push_rx(8'h01, 2'd0, 1'b0); push_rx(8'h02, 2'd0, 1'b0);
        idle(1);
        rd(8'h3C, "R9 below threshold", 32'h0);
        push_rx(8'h03, 2'd0, 1'b0);
        idle(1);
        rd(8'h3C, "R9 at threshold", 32'h4000_0000);
        for (int i = 0; i < 63; i++) push_rx(8'(i), 2'd1, 1'b0);
        idle(1);
        rd(8'h0C, "R11 rx capped", 32'h0040_0300);
        rd(8'h3C, "R9 full flag", 32'hC000_0000);
        wr(8'h38, 32'h8000_0000);
        check("R9 full irq", {31'b0, irq}, 32'h1);
        wr(8'h0C, 32'h8000_0300);
        rd(8'h0C, "R4 rx flushed", 32'h0000_0300);
        wr(8'h3C, 32'hC000_0000);
        rd(8'h3C, "R9 flags cleared", 32'h0);
        wr(8'h38, 32'h0);

        // R11 transmit bound
        for (int i = 0; i < 66; i++) wr(8'h40, 32'(i));
        pops = 0; lastd = 0;
        while (eng_tx_valid && pops < 100) begin
            lastd = eng_tx_data; pop_tx(); pops++;
        end
        check("R11 tx capacity", 32'(pops), 32'd64);
        check("R11 tx last kept", {24'b0, lastd}, 32'd63);
        wr(8'h40, 32'h55);
        wr(8'h0C, 32'h4000_0300);
        check("R4 tx flushed", {31'b0, eng_tx_valid}, 32'h0);

        // R5 disabled start ignored
        wr(8'h00, 32'h0005_0000);
        wr(8'h30, 32'h8000_0E00);
        check("R5 disabled no start", {31'b0, eng_start}, 32'h0);
        rd(8'h30, "R5 disabled fields", 32'h0000_1004);

        // R10 soft reset with work in flight
        wr(8'h00, 32'h4000_0000);
        wr(8'h30, 32'h8000_0E00);
        wr(8'h40, 32'h77);
        push_rx(8'h10, 2'd0, 1'b0); push_rx(8'h11, 2'd0, 1'b0); push_rx(8'h12, 2'd0, 1'b0);
        idle(1);
        rd(8'h3C, "R10 pre flag", 32'h4000_0000);
        wr(8'h00, 32'hC000_0000);
        wr(8'h30, 32'h8000_0E00);
        check("R10 start refused", {31'b0, eng_start}, 32'h0);
        wr(8'h00, 32'h4000_0000);
        rd(8'h30, "R10 cmd cleared", 32'h0);
        rd(8'h0C, "R10 rx emptied", 32'h0000_0300);
        check("R10 tx emptied", {31'b0, eng_tx_valid}, 32'h0);
        rd(8'h3C, "R10 status cleared", 32'h0);
        wr(8'h30, 32'h8000_0E00);
        check("R10 recovery start", {31'b0, eng_start}, 32'h1);
        done(3'd1);
        rd(8'h30, "R7 lost arbitration", 32'h0200_0E00);
        done(3'd4);
        rd(8'h30, "R7 idle done ignored", 32'h0200_0E00);

        idle(2);
        finish_run();
    end
endmodule